// File: doc/BRIEF.md
# Software Store/Recall Command Detector

This block watches read accesses to a nonvolatile-backed SRAM and recognises a fixed chain of six read addresses. Software uses the chain to start a nonvolatile operation without a dedicated pin. Five fixed addresses come first and are shared by both commands. The sixth address picks the command: one value asks for a STORE of the SRAM into the nonvolatile array, and another asks for a RECALL from it.

An access is a cycle in which the access strobe is high and chip enable (active low) is asserted. Cycles that are not accesses are ignored. A write, or an address that is not the next one expected, abandons a partial chain. When the sixth address completes the chain, the block raises a one-cycle request pulse to the mode controller. For the five leading reads the SRAM returns normal data; the controller then performs the operation. While that operation runs the detector ignores all traffic.

Top module: `swseq_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, the detector returns to idle, and `store_req` and `recall_req` are low in the following cycle.
- R2: Six consecutive read accesses (`we_n` high) with low address bits 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0 raise `store_req` for exactly the one cycle after the clock edge that samples the sixth access.
- R3: The same five leading addresses followed by 0x0C63 raise `recall_req` in the same way.
- R4: Only `addr[13:0]` is compared. Bit 14 may take any value on any access of the chain without changing the outcome.
- R5: An access with `we_n` low aborts any partial chain, so the remaining addresses of that chain produce no request.
- R6: A read access whose address is not the next expected entry aborts the partial chain.
- R7: When that non-matching address equals the first sequence address 0x0E38, it counts as the first entry of a new chain.
- R8: Cycles with `cyc_stb` low or `ce_n` high neither advance nor abort a chain.
- R9: While `nv_busy` is high, accesses are ignored, no request is raised, and any partial chain is dropped.
- R10: `store_req` and `recall_req` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_stb | input | 1 | High for the cycle that samples one memory access |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (15) | Access address; only bits 13:0 are compared |
| nv_busy | input | 1 | A nonvolatile operation is in progress |
| store_req | output | 1 | One-cycle STORE request |
| recall_req | output | 1 | One-cycle RECALL request |

## Verification
Two events can fall in the same cycle: an address that breaks a chain can also be the first entry of a new chain, and a completing sixth access can coincide with a high `nv_busy`. Directed cases cover both. In one, 0x0E38 replaces a later prefix entry and a store must still follow the rest of the chain. In the other, the whole chain runs with `nv_busy` held high and no pulse may appear. Random traffic that leans toward sequence addresses, with random writes, gaps and busy periods, is compared each cycle against a bench model of the chain.

// File: rtl/swseq_pkg.sv
// Package: shared types and constants of the software command detector.
// Assumes the command chain is fixed at six 14-bit addresses.
package swseq_pkg;

    localparam int unsigned SEQ_W      = 14;
    localparam int unsigned PREFIX_LEN = 5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_M1   = 3'd1,
        ST_M2   = 3'd2,
        ST_M3   = 3'd3,
        ST_M4   = 3'd4,
        ST_M5   = 3'd5
    } seq_state_t;

    localparam logic [SEQ_W-1:0] CODE_STORE  = 14'h0FC0;
    localparam logic [SEQ_W-1:0] CODE_RECALL = 14'h0C63;

    // Leading address of the chain at position idx (0..PREFIX_LEN-1).
    function automatic logic [SEQ_W-1:0] prefix_code(input int unsigned idx);
        case (idx)
            0:       return 14'h0E38;
            1:       return 14'h31C7;
            2:       return 14'h03E0;
            3:       return 14'h3C1F;
            default: return 14'h303F;
        endcase
    endfunction

endpackage

// File: rtl/swseq_match.sv
// Module: swseq_match
// Compares the low address bits against every chain entry in parallel.
// Assumes the address is already cut to SEQ_W bits; purely combinational.
module swseq_match
    import swseq_pkg::*;
(
    input  logic [SEQ_W-1:0]      low_addr,
    output logic [PREFIX_LEN-1:0] hit_step,
    output logic                  hit_store,
    output logic                  hit_recall
);

    // One comparator per leading chain entry.
    for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_prefix
        assign hit_step[g] = (low_addr == prefix_code(g));
    end

    // Comparators for the two command-selecting final entries.
    assign hit_store  = (low_addr == CODE_STORE);
    assign hit_recall = (low_addr == CODE_RECALL);

endmodule

// File: rtl/swseq_fsm.sv
// Module: swseq_fsm
// Tracks how many chain entries have matched and issues the request pulse.
// Assumes the hit inputs come from swseq_match for the current access.
module swseq_fsm
    import swseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc,
    input  logic                  wr,
    input  logic                  nv_busy,
    input  logic [PREFIX_LEN-1:0] hit_step,
    input  logic                  hit_store,
    input  logic                  hit_recall,
    output logic                  store_req,
    output logic                  recall_req
);

    seq_state_t state, state_d;
    seq_state_t restart;
    logic       st_d, rc_d;

    // Next-state and request decode for one qualified access.
    always_comb begin
        state_d = state;
        st_d    = 1'b0;
        rc_d    = 1'b0;
        restart = hit_step[0] ? ST_M1 : ST_IDLE;
        if (nv_busy) begin
            state_d = ST_IDLE;
        end else if (acc) begin
            if (wr) begin
                state_d = ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: state_d = restart;
                    ST_M1:   state_d = hit_step[1] ? ST_M2 : restart;
                    ST_M2:   state_d = hit_step[2] ? ST_M3 : restart;
                    ST_M3:   state_d = hit_step[3] ? ST_M4 : restart;
                    ST_M4:   state_d = hit_step[4] ? ST_M5 : restart;
                    ST_M5: begin
                        if (hit_store) begin
                            st_d    = 1'b1;
                            state_d = ST_IDLE;
                        end else if (hit_recall) begin
                            rc_d    = 1'b1;
                            state_d = ST_IDLE;
                        end else begin
                            state_d = restart;
                        end
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    // State and request registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            state      <= state_d;
            store_req  <= st_d;
            recall_req <= rc_d;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE && !store_req && !recall_req));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |=> !(store_req || recall_req));

    // R5
    write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr) |=> (state == ST_IDLE && !store_req && !recall_req));

    // R9
    busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |=> (state == ST_IDLE && !store_req && !recall_req));

    // R2
    store_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !wr && !nv_busy && state == ST_M5 && hit_store) |=> store_req);

    // R8
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !nv_busy) |=> $stable(state));

endmodule

// File: rtl/swseq_detect.sv
// Module: swseq_detect (top)
// Recognises the six-read software STORE/RECALL command chain.
// Assumes cyc_stb marks exactly one cycle per chip-enable-controlled access.
module swseq_detect
    import swseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              nv_busy,
    output logic              store_req,
    output logic              recall_req
);

    logic                  acc;
    logic                  wr;
    logic [PREFIX_LEN-1:0] hit_step;
    logic                  hit_store;
    logic                  hit_recall;

    // Qualify an access and its direction.
    assign acc = cyc_stb & ~ce_n;
    assign wr  = ~we_n;

    // Upper address bits take no part in the match.
    if (ADDR_W > SEQ_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^addr[ADDR_W-1:SEQ_W];
    end

    swseq_match u_match (
        .low_addr   (addr[SEQ_W-1:0]),
        .hit_step   (hit_step),
        .hit_store  (hit_store),
        .hit_recall (hit_recall)
    );

    swseq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .wr         (wr),
        .nv_busy    (nv_busy),
        .hit_step   (hit_step),
        .hit_store  (hit_store),
        .hit_recall (hit_recall),
        .store_req  (store_req),
        .recall_req (recall_req)
    );

endmodule

// File: tb/sim_swseq_detect.sv
// Bench: directed chains plus seeded random traffic against a bench model.
module sim_swseq_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_stb = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [14:0] addr = '0;
    logic        nv_busy = 1'b0;
    logic        store_req, recall_req;

    int checks = 0;
    int errors = 0;
    int m_state = 0;

    always #10 clk = ~clk;

    swseq_detect u0 (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ce_n(ce_n),
        .we_n(we_n), .addr(addr), .nv_busy(nv_busy),
        .store_req(store_req), .recall_req(recall_req)
    );

    function automatic logic [13:0] chain(input int i);
        case (i)
            0: return 14'h0E38;
            1: return 14'h31C7;
            2: return 14'h03E0;
            3: return 14'h3C1F;
            4: return 14'h303F;
            5: return 14'h0FC0;
            default: return 14'h0C63;
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Drive one cycle, update the model, check outputs after the edge.
    task automatic apply(input logic stb, input logic cen, input logic wen,
                         input logic [14:0] a, input logic busy, input string tag);
        logic es, er;
        logic [13:0] lo;
        es = 1'b0; er = 1'b0; lo = a[13:0];
        if (busy) m_state = 0;
        else if (stb && !cen) begin
            if (!wen) m_state = 0;
            else if (m_state < 5 && lo == chain(m_state)) m_state++;
            else if (m_state == 5 && lo == chain(5)) begin es = 1'b1; m_state = 0; end
            else if (m_state == 5 && lo == chain(6)) begin er = 1'b1; m_state = 0; end
            else m_state = (lo == chain(0)) ? 1 : 0;
        end
        @(negedge clk);
        cyc_stb = stb; ce_n = cen; we_n = wen; addr = a; nv_busy = busy;
        @(posedge clk);
        #5;
        check(store_req, es, {tag, " store_req"});
        check(recall_req, er, {tag, " recall_req"});
        checks++;
        if (store_req && recall_req) begin
            errors++;
            $display("FAIL R10 actual=both expected=at most one");
        end
    endtask

    task automatic rd(input int i, input logic b14, input string tag);
        apply(1'b1, 1'b0, 1'b1, {b14, chain(i)}, 1'b0, tag);
    endtask

    task automatic idle(input string tag);
        apply(1'b0, 1'b1, 1'b1, 15'h0, 1'b0, tag);
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        @(posedge clk); #5;
        // R1: outputs low under reset
        check(store_req, 1'b0, "R1 store_req");
        check(recall_req, 1'b0, "R1 recall_req");
        @(negedge clk); rst_n = 1'b1;

        // R2: store chain
        for (int i = 0; i < 6; i++) rd(i, 1'b0, "R2");
        idle("R10 after store");
        // R3: recall chain
        for (int i = 0; i < 5; i++) rd(i, 1'b0, "R3");
        rd(6, 1'b0, "R3");
        idle("R10 after recall");
        // R4: bit 14 set on every access
        for (int i = 0; i < 6; i++) rd(i, 1'b1, "R4");
        // R5: write mid-chain aborts
        for (int i = 0; i < 3; i++) rd(i, 1'b0, "R5");
        apply(1'b1, 1'b0, 1'b0, {1'b0, chain(3)}, 1'b0, "R5 write");
        for (int i = 3; i < 6; i++) rd(i, 1'b0, "R5 tail");
        // R6: wrong address aborts
        rd(0, 1'b0, "R6"); rd(1, 1'b0, "R6");
        apply(1'b1, 1'b0, 1'b1, 15'h1234, 1'b0, "R6 wrong");
        for (int i = 2; i < 6; i++) rd(i, 1'b0, "R6 tail");
        // R7: first address restarts the chain
        for (int i = 0; i < 3; i++) rd(i, 1'b0, "R7");
        rd(0, 1'b0, "R7 restart");
        for (int i = 1; i < 6; i++) rd(i, 1'b0, "R7 tail");
        // R8: gaps of strobe-low and deselected cycles
        for (int i = 0; i < 6; i++) begin
            rd(i, 1'b0, "R8");
            if (i < 5) begin
                idle("R8 gap");
                apply(1'b1, 1'b1, 1'b0, 15'h7FFF, 1'b0, "R8 deselect");
            end
        end
        // R9: whole chain while busy, then tail after busy
        for (int i = 0; i < 6; i++)
            apply(1'b1, 1'b0, 1'b1, {1'b0, chain(i)}, 1'b1, "R9 busy");
        for (int i = 0; i < 4; i++) rd(i, 1'b0, "R9");
        apply(1'b0, 1'b1, 1'b1, 15'h0, 1'b1, "R9 busy gap");
        rd(4, 1'b0, "R9 tail"); rd(5, 1'b0, "R9 tail");

        // Random traffic leaning toward chain addresses
        for (int n = 0; n < 4000; n++) begin
            logic [14:0] a;
            int r;
            r = int'($urandom_range(0, 9));
            a = (r < 7) ? {1'($urandom), chain(r)} : 15'($urandom);
            if (r < 6 && m_state == r) a[13:0] = chain(r);
            apply(($urandom_range(0, 9) != 0), ($urandom_range(0, 15) == 0),
                  ($urandom_range(0, 19) != 0), a, ($urandom_range(0, 39) == 0),
                  "R2/R3 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule